// File: doc/BRIEF.md
# Staged Page-Protected EEPROM Controller

This block sits behind a serial bus's addressing layer and handles the memory commands of a small paged non-volatile store. Data never goes straight to the array: a write command first fills an eight-byte staging buffer aligned to eight bytes. The buffer records the target address and a status byte that holds the last offset written and an incomplete-write flag. The host can read the buffer back to confirm it. Only then does a commit command move it into the array. The commit needs three things: the host must echo the stored address and status, an external authentication comparator must report a match, and the target page must not be locked.

Each page can be locked against commits. One page, fixed by a parameter, can be switched into one-time-programmable emulation, in which a commit can only clear bits. A bus reset aborts whatever command is open and never alters the array. An accepted commit holds a busy flag for a fixed number of cycles. While it is up, all new traffic is ignored, and the array is written only in the last busy cycle.

Top module: `eep_staged_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy`, `copy_done` and `copy_fail` are 0, `sp_addr` is 0x0000, `sp_stat` is 0x80, and every array byte reads 0xFF.
- R2: Command code 0 (stage write) latches `cmd_addr` into `sp_addr`. Each following `dat_valid` byte goes to buffer offset `cmd_addr[2:0]`, then the next offset, up to offset 7. Bytes beyond offset 7 are dropped, and the array is not touched.
- R3: Command code 1 (stage read) returns buffer bytes on `rd_data`, one cycle after each `rd_req`. Reading starts at offset `sp_addr[2:0]` and the offset wraps from 7 back to 0.
- R4: `sp_stat` bit 7 is the incomplete flag. Bits 6..3 are 0 and bits 2..0 hold the last offset written. Bit 7 is 1 from the cycle after a stage write opens until `cmd_stop` closes that write with at least one byte stored.
- R5: Command code 2 (commit) is accepted only when `cmd_addr` equals `sp_addr`, `cmd_stat` equals `sp_stat`, `sp_stat` bit 7 is 0 and `auth_match` is 1. Otherwise `copy_fail` pulses for one cycle in the cycle after the command and the array keeps its contents.
- R6: An accepted commit holds `busy` high for exactly COPY_CYCLES cycles. `copy_done` then pulses for one cycle, and array bytes from block base `sp_addr & ~7` plus offsets `sp_addr[2:0]` through `sp_stat[2:0]` take the buffer bytes at those offsets. No other array byte changes.
- R7: While `busy` is high, `cmd_start`, `dat_valid`, `cmd_stop` and `rd_req` are ignored.
- R8: A commit aimed at a page whose `page_wp` bit is 1 is refused with `copy_fail`. A page is PAGE_BYTES bytes, so the page number is `sp_addr[AW-1:log2(PAGE_BYTES)]`. The array stays unchanged.
- R9: When `emu_en` is 1 and the commit targets page EMU_PAGE, each written byte becomes the old array byte ANDed with the buffer byte.
- R10: `bus_reset` closes any open command. A stage write cut short this way leaves `sp_stat` bit 7 at 1. During `busy`, `bus_reset` drops `busy` at once with no `copy_done` and no array change.
- R11: Command code 3 (array read) returns array bytes one cycle after each `rd_req`. Reading starts at `cmd_addr` and the address wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the array to 0xFF |
| bus_reset | input | 1 | Aborts the open command; array untouched |
| cmd_start | input | 1 | Starts a command |
| cmd_op | input | 2 | Command code: 0 stage write, 1 stage read, 2 commit, 3 array read |
| cmd_addr | input | 16 | Target address (stage write, commit, array read) |
| cmd_stat | input | 8 | Status byte echoed with a commit |
| auth_match | input | 1 | Authentication comparator result, sampled with a commit |
| dat_valid | input | 1 | Data byte strobe during a stage write |
| dat_in | input | 8 | Data byte |
| cmd_stop | input | 1 | Closes a stage write |
| rd_req | input | 1 | Requests the next read byte |
| page_wp | input | DEPTH/PAGE_BYTES | Per-page commit lock |
| emu_en | input | 1 | Enables bit-clear-only mode on page EMU_PAGE |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Commit in progress |
| copy_done | output | 1 | One-cycle pulse when a commit lands |
| copy_fail | output | 1 | One-cycle pulse when a commit is refused |
| sp_addr | output | 16 | Stored target address |
| sp_stat | output | 8 | Stored status byte |

## Verification
The staging path is driven with a write that starts mid-block and overruns offset 7. Reading it back shows whether surplus bytes were dropped or wrapped over the start of the buffer. Commits are tried with a wrong status, a wrong address, no authentication, an incomplete buffer and a locked page, and each refusal is confirmed by reading the array back. Two successive commits to the emulation page, with complementary patterns, separate an AND merge from a plain overwrite. A bus reset during busy, and a commit into block 0 read across the top-address wrap, cover the abort and read-pointer boundaries.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [1:0] {
      OP_STAGE_WR = 2'd0,
      OP_STAGE_RD = 2'd1,
      OP_COMMIT   = 2'd2,
      OP_ARRAY_RD = 2'd3
   } eep_op_e;

   typedef enum logic [1:0] {
      M_IDLE,
      M_WRITE,
      M_RD_STAGE,
      M_RD_ARRAY
   } eep_mode_e;

   localparam int STAGE_BYTES = 8;
endpackage

// File: rtl/eep_stage_buf.sv
module eep_stage_buf (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        open_i,
   input  logic [15:0] addr_i,
   input  logic        byte_i,
   input  logic [7:0]  data_i,
   input  logic        close_i,
   output logic [63:0] buf_o,
   output logic [15:0] addr_o,
   output logic [7:0]  stat_o
);
   logic [63:0] buf_q;
   logic [15:0] addr_q;
   logic [2:0]  wptr_q, eoff_q;
   logic        full_q, wrote_q, inc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         addr_q  <= '0;
         wptr_q  <= '0;
         eoff_q  <= '0;
         full_q  <= 1'b0;
         wrote_q <= 1'b0;
         inc_q   <= 1'b1;
      end else if (open_i) begin
         addr_q  <= addr_i;
         wptr_q  <= addr_i[2:0];
         eoff_q  <= addr_i[2:0];
         full_q  <= 1'b0;
         wrote_q <= 1'b0;
         inc_q   <= 1'b1;
      end else begin
         if (byte_i && !full_q) begin
            buf_q[{wptr_q, 3'b000} +: 8] <= data_i;
            eoff_q  <= wptr_q;
            wrote_q <= 1'b1;
            if (wptr_q == 3'd7) full_q <= 1'b1;
            else                wptr_q <= wptr_q + 3'd1;
         end
         if (close_i) inc_q <= !wrote_q;
      end
   end

   assign buf_o  = buf_q;
   assign addr_o = addr_q;
   assign stat_o = {inc_q, 4'b0000, eoff_q};
endmodule

// File: rtl/eep_commit_timer.sv
module eep_commit_timer #(
   parameter int CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic last_o
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign last_o = busy_q && (cnt_q == '0) && !abort_i;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int DEPTH       = 128,
   parameter bit EMU_SUPPORT = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit_i,
   input  logic [AW-4:0] blk_i,
   input  logic [2:0]    first_i,
   input  logic [2:0]    last_i,
   input  logic [63:0]   buf_i,
   input  logic          emu_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [7:0]    rd_data_o
);
   logic [DEPTH*8-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      localparam int J = g % 8;
      localparam int B = g / 8;
      logic [7:0] cell_q, next_v;
      logic       hit;

      assign hit = commit_i && (blk_i == (AW-3)'(B)) &&
                   (3'(J) >= first_i) && (3'(J) <= last_i);

      if (EMU_SUPPORT) begin : g_emu
         assign next_v = emu_i ? (cell_q & buf_i[J*8 +: 8]) : buf_i[J*8 +: 8];
      end else begin : g_plain
         assign next_v = buf_i[J*8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cell_q <= 8'hFF;
         else if (hit) cell_q <= next_v;
      end

      assign flat[g*8 +: 8] = cell_q;
   end

   assign rd_data_o = flat[{rd_addr_i, 3'b000} +: 8];
endmodule

// File: rtl/eep_staged_ctrl.sv
module eep_staged_ctrl
   import eep_pkg::*;
#(
   parameter int DEPTH       = 128,
   parameter int PAGE_BYTES  = 32,
   parameter int COPY_CYCLES = 10,
   parameter int EMU_PAGE    = 3,
   parameter bit EMU_SUPPORT = 1'b1,
   localparam int NPAGES = DEPTH / PAGE_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              cmd_start,
   input  logic [1:0]        cmd_op,
   input  logic [15:0]       cmd_addr,
   input  logic [7:0]        cmd_stat,
   input  logic              auth_match,
   input  logic              dat_valid,
   input  logic [7:0]        dat_in,
   input  logic              cmd_stop,
   input  logic              rd_req,
   input  logic [NPAGES-1:0] page_wp,
   input  logic              emu_en,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              copy_done,
   output logic              copy_fail,
   output logic [15:0]       sp_addr,
   output logic [7:0]        sp_stat
);
   localparam int AW  = $clog2(DEPTH);
   localparam int PW  = $clog2(PAGE_BYTES);
   localparam int PGW = AW - PW;

   if (DEPTH % PAGE_BYTES != 0 || PAGE_BYTES < STAGE_BYTES ||
       (PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || NPAGES < 2 ||
       EMU_PAGE >= NPAGES || COPY_CYCLES < 1 || DEPTH > 65536) begin : g_bad_cfg
      $error("eep_staged_ctrl: invalid parameter set");
   end

   eep_mode_e     mode_q;
   logic [AW-1:0] ptr_q;
   logic [63:0]   buf_w;
   logic [7:0]    arr_rd;
   logic          go, open_w, byte_w, close_w, rd_fire;
   logic          is_commit, commit_ok, last_w, emu_hit;
   logic [PGW-1:0] page_w;

   assign go        = cmd_start && !busy && !bus_reset;
   assign open_w    = go && (cmd_op == OP_STAGE_WR);
   assign byte_w    = (mode_q == M_WRITE) && dat_valid && !busy && !bus_reset && !go;
   assign close_w   = (mode_q == M_WRITE) && cmd_stop && !busy && !bus_reset && !go;
   assign rd_fire   = rd_req && !busy && !bus_reset && !go &&
                      ((mode_q == M_RD_STAGE) || (mode_q == M_RD_ARRAY));
   assign page_w    = sp_addr[AW-1:PW];
   assign is_commit = go && (cmd_op == OP_COMMIT);
   assign commit_ok = is_commit && (cmd_addr == sp_addr) && (cmd_stat == sp_stat) &&
                      !sp_stat[7] && auth_match && !page_wp[page_w];
   assign emu_hit   = emu_en && (page_w == PGW'(EMU_PAGE));

   eep_stage_buf i_stage (
      .clk(clk), .rst_n(rst_n), .open_i(open_w), .addr_i(cmd_addr),
      .byte_i(byte_w), .data_i(dat_in), .close_i(close_w),
      .buf_o(buf_w), .addr_o(sp_addr), .stat_o(sp_stat)
   );

   eep_commit_timer #(.CYCLES(COPY_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .start_i(commit_ok), .abort_i(bus_reset),
      .busy_o(busy), .last_o(last_w)
   );

   eep_array #(.DEPTH(DEPTH), .EMU_SUPPORT(EMU_SUPPORT)) i_array (
      .clk(clk), .rst_n(rst_n), .commit_i(last_w), .blk_i(sp_addr[AW-1:3]),
      .first_i(sp_addr[2:0]), .last_i(sp_stat[2:0]), .buf_i(buf_w),
      .emu_i(emu_hit), .rd_addr_i(ptr_q), .rd_data_o(arr_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= M_IDLE;
         ptr_q     <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         copy_done <= 1'b0;
         copy_fail <= 1'b0;
      end else begin
         rd_valid  <= rd_fire;
         copy_done <= last_w;
         copy_fail <= is_commit && !commit_ok;
         if (bus_reset) begin
            mode_q <= M_IDLE;
         end else if (go) begin
            unique case (cmd_op)
               OP_STAGE_WR: mode_q <= M_WRITE;
               OP_STAGE_RD: begin
                  mode_q <= M_RD_STAGE;
                  ptr_q  <= sp_addr[AW-1:0];
               end
               OP_ARRAY_RD: begin
                  mode_q <= M_RD_ARRAY;
                  ptr_q  <= cmd_addr[AW-1:0];
               end
               default:     mode_q <= M_IDLE;
            endcase
         end else if (close_w) begin
            mode_q <= M_IDLE;
         end
         if (rd_fire) begin
            rd_data <= (mode_q == M_RD_STAGE) ? buf_w[{ptr_q[2:0], 3'b000} +: 8] : arr_rd;
            ptr_q   <= ptr_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/eep_staged_ctrl_chk.sv
module eep_staged_ctrl_chk #(
   parameter int COPY_CYCLES = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_reset,
   input logic       cmd_start,
   input logic [1:0] cmd_op,
   input logic       auth_match,
   input logic       rd_valid,
   input logic       busy,
   input logic       copy_done,
   input logic       copy_fail,
   input logic [7:0] sp_stat
);
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < COPY_CYCLES)) else $error("busy too long"); // R6
   AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |-> (!busy && $past(busy))) else $error("done without busy"); // R6
   AST_BUSY_NEEDS_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cmd_start) && $past(auth_match) && $past(cmd_op) == 2'd2)) else $error("busy without commit"); // R5
   AST_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      copy_fail |-> !busy) else $error("fail with busy"); // R5
   AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_valid) else $error("read while busy"); // R7
   AST_WRITE_OPENS_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_op == 2'd0 && !busy && !bus_reset) |=> sp_stat[7]) else $error("inc flag"); // R4
   AST_ABORT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (!busy && !copy_done)) else $error("abort"); // R10
endmodule

bind eep_staged_ctrl eep_staged_ctrl_chk #(.COPY_CYCLES(COPY_CYCLES)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cmd_start(cmd_start),
   .cmd_op(cmd_op), .auth_match(auth_match), .rd_valid(rd_valid), .busy(busy),
   .copy_done(copy_done), .copy_fail(copy_fail), .sp_stat(sp_stat)
);

// File: tb/test_eep_staged_ctrl.sv
module test_eep_staged_ctrl;
   localparam int CC = 10;
   logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, cmd_start = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [15:0] cmd_addr = '0;
   logic [7:0] cmd_stat = '0, dat_in = '0, rd_data, sp_stat;
   logic auth_match = 1'b0, dat_valid = 1'b0, cmd_stop = 1'b0, rd_req = 1'b0, emu_en = 1'b0;
   logic [3:0] page_wp = '0;
   logic rd_valid, busy, copy_done, copy_fail;
   logic [15:0] sp_addr;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   eep_staged_ctrl #(.COPY_CYCLES(CC)) i_eep_staged_ctrl (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(logic [1:0] op, logic [15:0] a, logic [7:0] s);
      @(negedge clk); cmd_start = 1'b1; cmd_op = op; cmd_addr = a; cmd_stat = s;
      @(negedge clk); cmd_start = 1'b0;
   endtask

   task automatic wbyte(logic [7:0] d);
      dat_valid = 1'b1; dat_in = d; @(negedge clk); dat_valid = 1'b0;
   endtask

   task automatic rbyte(output logic [7:0] d, output logic v);
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; d = rd_data; v = rd_valid;
   endtask

   task automatic stage(logic [15:0] a, int n, logic [7:0] base);
      cmd(2'd0, a, 8'h00);
      for (int i = 0; i < n; i++) wbyte(base + 8'(i));
      cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
   endtask

   task automatic stage1(logic [15:0] a, logic [7:0] b0, logic [7:0] b1);
      cmd(2'd0, a, 8'h00); wbyte(b0); wbyte(b1);
      cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
   endtask

   task automatic mem_at(logic [15:0] a, string req, logic [7:0] exp);
      logic [7:0] d; logic v;
      cmd(2'd3, a, 8'h00); rbyte(d, v);
      chk(req, {v, d}, {1'b1, exp});
   endtask

   task automatic commit_wait(logic [15:0] a, logic [7:0] s, string req);
      int n = 0;
      auth_match = 1'b1; cmd(2'd2, a, s); auth_match = 1'b0;
      chk(req, copy_fail, 1'b0);
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk("R6 busy length", n, CC);
      chk("R6 done pulse", copy_done, 1'b1);
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 1'b0);
      chk("R1 done/fail", {copy_done, copy_fail}, 2'b00);
      chk("R1 addr", sp_addr, 16'h0000);
      chk("R1 stat", sp_stat, 8'h80);
      mem_at(16'h0013, "R1 array erased", 8'hFF);
   endtask

   task automatic t_stage();
      logic [7:0] d; logic v;
      stage(16'h0013, 7, 8'hA0);
      chk("R2 addr latched", sp_addr, 16'h0013);
      chk("R4 stat after stop", sp_stat, 8'h07);
      mem_at(16'h0013, "R2 array untouched", 8'hFF);
      cmd(2'd1, 16'h0000, 8'h00);
      for (int i = 0; i < 5; i++) begin
         rbyte(d, v); chk("R3 stage readback", {v, d}, {1'b1, 8'hA0 + 8'(i)});
      end
      rbyte(d, v); chk("R3 wrap / R2 overrun dropped", {v, d}, {1'b1, 8'h00});
   endtask

   task automatic t_refuse();
      auth_match = 1'b1; cmd(2'd2, 16'h0013, 8'h06);
      chk("R5 wrong stat", copy_fail, 1'b1);
      cmd(2'd2, 16'h0012, 8'h07);
      chk("R5 wrong addr", copy_fail, 1'b1);
      auth_match = 1'b0; cmd(2'd2, 16'h0013, 8'h07);
      chk("R5 no auth", copy_fail, 1'b1);
      chk("R5 no busy", busy, 1'b0);
      mem_at(16'h0013, "R5 array unchanged", 8'hFF);
   endtask

   task automatic t_commit();
      commit_wait(16'h0013, 8'h07, "R5 accept");
      mem_at(16'h0012, "R6 below range", 8'hFF);
      mem_at(16'h0013, "R6 first", 8'hA0);
      mem_at(16'h0017, "R6 last", 8'hA4);
      mem_at(16'h0018, "R6 next block", 8'hFF);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] d; logic v;
      stage(16'h0008, 1, 8'h11);
      auth_match = 1'b1; cmd(2'd2, 16'h0008, 8'h00); auth_match = 1'b0;
      chk("R7 busy", busy, 1'b1);
      cmd(2'd0, 16'h0077, 8'h00);
      chk("R7 cmd ignored", sp_addr, 16'h0008);
      rbyte(d, v);
      chk("R7 rd ignored", v, 1'b0);
      while (busy) @(negedge clk);
      mem_at(16'h0008, "R7 commit intact", 8'h11);
   endtask

   task automatic t_wp();
      page_wp = 4'b0010;
      stage(16'h0025, 2, 8'h31);
      chk("R8 stat", sp_stat, 8'h06);
      auth_match = 1'b1; cmd(2'd2, 16'h0025, 8'h06); auth_match = 1'b0;
      chk("R8 refused", copy_fail, 1'b1);
      mem_at(16'h0025, "R8 unchanged", 8'hFF);
      page_wp = 4'b0000;
   endtask

   task automatic t_emu();
      emu_en = 1'b1;
      stage1(16'h0060, 8'hF0, 8'h3C);
      commit_wait(16'h0060, 8'h01, "R9 accept 1");
      mem_at(16'h0060, "R9 first write", 8'hF0);
      stage1(16'h0060, 8'h0F, 8'hFF);
      commit_wait(16'h0060, 8'h01, "R9 accept 2");
      mem_at(16'h0060, "R9 AND merge", 8'h00);
      mem_at(16'h0061, "R9 AND keep", 8'h3C);
      emu_en = 1'b0;
   endtask

   task automatic t_abort();
      cmd(2'd0, 16'h0040, 8'h00); wbyte(8'h55);
      bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
      chk("R10 inc flag kept", sp_stat, 8'h80);
      auth_match = 1'b1; cmd(2'd2, 16'h0040, 8'h80); auth_match = 1'b0;
      chk("R10 incomplete refused", copy_fail, 1'b1);
      stage(16'h0040, 1, 8'h55);
      auth_match = 1'b1; cmd(2'd2, 16'h0040, 8'h00); auth_match = 1'b0;
      chk("R10 accepted", busy, 1'b1);
      repeat (3) @(negedge clk);
      bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
      chk("R10 busy dropped", busy, 1'b0);
      repeat (CC) @(negedge clk);
      chk("R10 no done", copy_done, 1'b0);
      mem_at(16'h0040, "R10 array unchanged", 8'hFF);
   endtask

   task automatic t_wrap();
      logic [7:0] d; logic v;
      stage(16'h0000, 1, 8'h5A);
      commit_wait(16'h0000, 8'h00, "R11 setup");
      cmd(2'd3, 16'h007F, 8'h00);
      rbyte(d, v); chk("R11 top byte", {v, d}, {1'b1, 8'hFF});
      rbyte(d, v); chk("R11 wrap to 0", {v, d}, {1'b1, 8'h5A});
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset(); t_stage(); t_refuse(); t_commit(); t_busy_ignore();
            t_wp(); t_emu(); t_abort(); t_wrap();
         end
         begin
            repeat (100000) @(negedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule